// File: doc/BRIEF.md
# SPI Status Request Router

This block sits beside an SPI controller's transfer engine and FIFOs and turns their status into request lines. Four one-cycle event pulses (frame finished, end of command queue, transmit underflow, receive overflow) each set a sticky flag. Software clears these flags by writing ones. Two level flags follow the live FIFO occupancy. One is true while the transmit FIFO has room. The other is true while the receive FIFO holds data.

A request enable register gates every flag, plus a combined overrun condition formed from the two error flags. A route register sends the transmit-room and receive-data conditions either to the shared interrupt line or to their own DMA request lines. Registers are written through a narrow port of address, data and strobe. The flags can be read on `flags_o`.

Top module: `spi_req_router`

## Requirements
- R1: After reset, the enable register and the route register are zero and all four sticky flags are clear. `irq_o`, `tx_dma_req_o` and `rx_dma_req_o` are low.
- R2: A pulse on `frame_done_i` sets flag bit 0, and a pulse on `queue_end_i` sets flag bit 1. Each flag is visible on `flags_o` after the clock edge that samples the pulse, and stays set afterwards.
- R3: A pulse on `tx_underflow_i` sets flag bit 2, and a pulse on `rx_overflow_i` sets flag bit 3. Both flags are sticky in the same way as in R2.
- R4: A write to address 2 clears each sticky flag whose data bit (0 to 3) is 1. Sticky flags whose data bit is 0 are left unchanged.
- R5: If an event pulse and a clear of the same flag fall in the same cycle, the flag stays set.
- R6: Flag bit 4 (transmit room) is 1 exactly when `tx_level_i` is below TX_DEPTH. It follows the input with no clock delay.
- R7: Flag bit 5 (receive data) is 1 exactly when `rx_level_i` is not zero. It follows the input with no clock delay.
- R8: A write to address 0 loads the enable register. Enable bits 0 to 5 match flag bits 0 to 5. A condition requests only while both its flag and its enable are 1.
- R9: A write to address 1 loads the route register. Bit 0 routes transmit room and bit 1 routes receive data. A route bit of 0 sends the condition to `irq_o`, and a route bit of 1 sends it to its own DMA line.
- R10: A condition routed to DMA never drives `irq_o`, and a condition routed to the interrupt never drives its DMA line.
- R11: Enable bit 6 gates an overrun condition, which is the OR of flag bits 2 and 3. When enabled, this condition drives `irq_o`.
- R12: A write to address 3 changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | One-cycle pulse when a serial frame ends |
| queue_end_i | input | 1 | One-cycle pulse when a frame carrying the end-of-queue mark ends |
| tx_underflow_i | input | 1 | One-cycle pulse on transmit FIFO underflow |
| rx_overflow_i | input | 1 | One-cycle pulse on receive FIFO overflow |
| tx_level_i | input | TX_LVL_W | Transmit FIFO entry count |
| rx_level_i | input | RX_LVL_W | Receive FIFO entry count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 enable, 1 route, 2 flag clear |
| wr_data_i | input | 7 | Register write data |
| flags_o | output | 6 | Flag vector (bit positions as in R2 to R7) |
| irq_o | output | 1 | Combined interrupt request |
| tx_dma_req_o | output | 1 | Transmit-room DMA request |
| rx_dma_req_o | output | 1 | Receive-data DMA request |

## Verification
The assertions assume that the FIFO level inputs never exceed their depths and that event inputs are single-cycle pulses from the engine. The stimulus drives levels only between zero and the depth. It raises each event for exactly one cycle, with all inputs changed on the falling clock edge. One directed case deliberately places an event and a matching clear in the same cycle, which is the only point where two writers of a sticky flag meet.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
  localparam int NUM_FLAGS  = 6;
  localparam int NUM_STICKY = 4;
  localparam int EN_W       = NUM_FLAGS + 1;
  localparam int NUM_ROUTE  = 2;

  // flag / enable bit positions
  localparam int F_FRAME   = 0;
  localparam int F_QEND    = 1;
  localparam int F_TXUF    = 2;
  localparam int F_RXOF    = 3;
  localparam int F_TXROOM  = 4;
  localparam int F_RXDATA  = 5;
  localparam int EN_OVRRUN = 6;

  localparam int RT_TX = 0;
  localparam int RT_RX = 1;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_ROUTE  = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/spi_req_cfg.sv
module spi_req_cfg
  import spi_req_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [1:0]            wr_addr_i,
  input  logic [EN_W-1:0]       wr_data_i,
  output logic [EN_W-1:0]       en_o,
  output logic [NUM_ROUTE-1:0]  route_o,
  output logic [NUM_STICKY-1:0] clr_o
);
  logic [EN_W-1:0]      en_q;
  logic [NUM_ROUTE-1:0] route_q;
  reg_addr_e            addr;

  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (wr_en_i) begin
      if (addr == REG_ENABLE) en_q    <= wr_data_i;
      if (addr == REG_ROUTE)  route_q <= wr_data_i[NUM_ROUTE-1:0];
    end
  end

  // write-one-to-clear strobe, one cycle wide
  assign clr_o   = (wr_en_i && addr == REG_CLEAR) ? wr_data_i[NUM_STICKY-1:0] : '0;
  assign en_o    = en_q;
  assign route_o = route_q;
endmodule

// File: rtl/spi_req_sticky.sv
module spi_req_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | (q & ~clr_i[i]); // set beats clear
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/spi_req_level.sv
module spi_req_level #(
  parameter int DEPTH      = 8,
  parameter bit CHECK_FULL = 1'b1,
  localparam int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level_i,
  output logic             flag_o
);
  if (CHECK_FULL) begin : g_room
    assign flag_o = level_i < LVL_W'(DEPTH);
  end else begin : g_data
    assign flag_o = level_i != '0;
  end
endmodule

// File: rtl/spi_req_router.sv
module spi_req_router
  import spi_req_pkg::*;
#(
  parameter int TX_DEPTH    = 8,
  parameter int RX_DEPTH    = 8,
  localparam int TX_LVL_W   = $clog2(TX_DEPTH + 1),
  localparam int RX_LVL_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_done_i,
  input  logic                 queue_end_i,
  input  logic                 tx_underflow_i,
  input  logic                 rx_overflow_i,
  input  logic [TX_LVL_W-1:0]  tx_level_i,
  input  logic [RX_LVL_W-1:0]  rx_level_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [EN_W-1:0]      wr_data_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_o,
  output logic                 tx_dma_req_o,
  output logic                 rx_dma_req_o
);
  logic [EN_W-1:0]       en_q;
  logic [NUM_ROUTE-1:0]  route_q;
  logic [NUM_STICKY-1:0] sticky_set, sticky_clr, sticky_q;
  logic                  tx_room, rx_data, overrun;
  logic                  tx_req, rx_req, sticky_irq;

  spi_req_cfg u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en_q), .route_o(route_q), .clr_o(sticky_clr)
  );

  assign sticky_set[F_FRAME] = frame_done_i;
  assign sticky_set[F_QEND]  = queue_end_i;
  assign sticky_set[F_TXUF]  = tx_underflow_i;
  assign sticky_set[F_RXOF]  = rx_overflow_i;

  spi_req_sticky #(.N(NUM_STICKY)) u_sticky (
    .clk_i, .rst_ni, .set_i(sticky_set), .clr_i(sticky_clr), .flag_o(sticky_q)
  );

  spi_req_level #(.DEPTH(TX_DEPTH), .CHECK_FULL(1'b1)) u_tx_lvl (
    .level_i(tx_level_i), .flag_o(tx_room)
  );
  spi_req_level #(.DEPTH(RX_DEPTH), .CHECK_FULL(1'b0)) u_rx_lvl (
    .level_i(rx_level_i), .flag_o(rx_data)
  );

  assign flags_o = {rx_data, tx_room, sticky_q};
  assign overrun = sticky_q[F_TXUF] | sticky_q[F_RXOF];

  assign tx_req     = tx_room & en_q[F_TXROOM];
  assign rx_req     = rx_data & en_q[F_RXDATA];
  assign sticky_irq = |(sticky_q & en_q[NUM_STICKY-1:0]) | (overrun & en_q[EN_OVRRUN]);

  assign irq_o        = sticky_irq | (tx_req & ~route_q[RT_TX]) | (rx_req & ~route_q[RT_RX]);
  assign tx_dma_req_o = tx_req & route_q[RT_TX];
  assign rx_dma_req_o = rx_req & route_q[RT_RX];
endmodule

// File: rtl/spi_req_router_chk.sv
module spi_req_router_chk
  import spi_req_pkg::*;
#(
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 8,
  localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
  localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_STICKY-1:0] set_i,
  input logic [NUM_STICKY-1:0] clr_i,
  input logic [EN_W-1:0]       en_i,
  input logic [NUM_ROUTE-1:0]  route_i,
  input logic [TX_LVL_W-1:0]   tx_level_i,
  input logic [RX_LVL_W-1:0]   rx_level_i,
  input logic [NUM_FLAGS-1:0]  flags_i,
  input logic                  irq_i,
  input logic                  tx_dma_i,
  input logic                  rx_dma_i
);
  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_flag
    p_event_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_i[i]);
    p_sticky_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_i[i] && !clr_i[i]) |=> flags_i[i]);
    p_clear_works_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flags_i[i]);
  end

  p_tx_dma_routed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_i |-> route_i[RT_TX]);
  p_rx_dma_routed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_i |-> route_i[RT_RX]);
  p_tx_dma_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_i |-> (tx_level_i < TX_LVL_W'(TX_DEPTH)));
  p_rx_dma_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_i |-> (rx_level_i != '0));
  p_no_enable_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !(irq_i || tx_dma_i || rx_dma_i));
  p_overrun_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i[EN_OVRRUN] && (flags_i[F_TXUF] || flags_i[F_RXOF])) |-> irq_i);
endmodule

bind spi_req_router spi_req_router_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sticky_set), .clr_i(sticky_clr),
  .en_i(en_q), .route_i(route_q), .tx_level_i(tx_level_i), .rx_level_i(rx_level_i),
  .flags_i(flags_o), .irq_i(irq_o), .tx_dma_i(tx_dma_req_o), .rx_dma_i(rx_dma_req_o)
);

// File: tb/spi_req_router_tb.sv
`timescale 1ns/1ps
module spi_req_router_tb_top;
  localparam int TXD = 8, RXD = 8, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_done = 0, queue_end = 0, tx_uf = 0, rx_of = 0;
  logic [LW-1:0] tx_lvl = 4'd8, rx_lvl = 4'd0;
  logic wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [5:0] flags;
  logic irq, txd, rxd;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spi_req_router #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_done_i(frame_done), .queue_end_i(queue_end),
    .tx_underflow_i(tx_uf), .rx_overflow_i(rx_of), .tx_level_i(tx_lvl), .rx_level_i(rx_lvl),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .flags_o(flags),
    .irq_o(irq), .tx_dma_req_o(txd), .rx_dma_req_o(rxd)
  );

  typedef struct packed {
    logic [3:0] tx; logic [3:0] rx; logic [6:0] en; logic [1:0] rt;
    logic irq; logic txd; logic rxd;
  } vec_t;
  localparam int NV = 10;
  // sticky flags are zero while the table runs
  localparam vec_t VEC [NV] = '{
    '{4'd3, 4'd0, 7'h10, 2'd0, 1'b1, 1'b0, 1'b0},
    '{4'd8, 4'd0, 7'h10, 2'd0, 1'b0, 1'b0, 1'b0},
    '{4'd3, 4'd0, 7'h10, 2'd1, 1'b0, 1'b1, 1'b0},
    '{4'd8, 4'd2, 7'h20, 2'd0, 1'b1, 1'b0, 1'b0},
    '{4'd8, 4'd2, 7'h20, 2'd2, 1'b0, 1'b0, 1'b1},
    '{4'd8, 4'd0, 7'h20, 2'd2, 1'b0, 1'b0, 1'b0},
    '{4'd0, 4'd8, 7'h30, 2'd3, 1'b0, 1'b1, 1'b1},
    '{4'd2, 4'd1, 7'h00, 2'd3, 1'b0, 1'b0, 1'b0},
    '{4'd8, 4'd0, 7'h7f, 2'd0, 1'b0, 1'b0, 1'b0},
    '{4'd7, 4'd5, 7'h10, 2'd2, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [6:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags", flags, 6'h00);
    check("R1 outputs", {irq, txd, rxd}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    tx_lvl = 4'd3;
    @(negedge clk);
    check("R1 enables zero", {irq, txd, rxd}, 3'b000);

    // R6 R7 R8 R9 R10 table
    for (int i = 0; i < NV; i++) begin
      tx_lvl = VEC[i].tx; rx_lvl = VEC[i].rx;
      wr(2'd0, VEC[i].en);
      wr(2'd1, {5'd0, VEC[i].rt});
      check("R6 room flag", flags[4], VEC[i].tx < 4'd8);
      check("R7 data flag", flags[5], VEC[i].rx != 4'd0);
      check("R8 R9 R10 routing", {irq, txd, rxd}, {VEC[i].irq, VEC[i].txd, VEC[i].rxd});
    end

    tx_lvl = 4'd8; rx_lvl = 4'd0;
    wr(2'd0, 7'h00); wr(2'd1, 7'h00);

    // R2 frame and queue-end events
    @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0;
    check("R2 frame flag", flags, 6'h01);
    check("R8 disabled flag", irq, 1'b0);
    wr(2'd0, 7'h01);
    check("R8 enabled flag", irq, 1'b1);
    @(negedge clk); queue_end = 1; @(negedge clk); queue_end = 0;
    repeat (3) @(negedge clk);
    check("R2 sticky", flags, 6'h03);

    // R4 clear
    wr(2'd2, 7'h00);
    check("R4 zero write keeps", flags, 6'h03);
    wr(2'd2, 7'h01);
    check("R4 clear bit0 only", flags, 6'h02);
    check("R4 irq drops", irq, 1'b0);
    wr(2'd2, 7'h02);
    check("R4 clear bit1", flags, 6'h00);

    // R3 and R11
    wr(2'd0, 7'h40);
    @(negedge clk); tx_uf = 1; @(negedge clk); tx_uf = 0;
    check("R3 underflow flag", flags, 6'h04);
    check("R11 overrun via underflow", irq, 1'b1);
    wr(2'd2, 7'h04);
    check("R11 overrun cleared", irq, 1'b0);
    @(negedge clk); rx_of = 1; @(negedge clk); rx_of = 0;
    check("R3 overflow flag", flags, 6'h08);
    check("R11 overrun via overflow", irq, 1'b1);
    wr(2'd2, 7'h08);

    // R5 event beats clear
    @(negedge clk); frame_done = 1; wr_en = 1; wr_addr = 2'd2; wr_data = 7'h01;
    @(negedge clk); frame_done = 0; wr_en = 0; wr_data = '0;
    check("R5 set wins", flags[0], 1'b1);
    wr(2'd2, 7'h0f);
    check("R4 clear all", flags, 6'h00);

    // R12 reserved address
    wr(2'd0, 7'h00); tx_lvl = 4'd3;
    wr(2'd3, 7'h7f);
    check("R12 enable untouched", {irq, txd, rxd}, 3'b000);
    wr(2'd0, 7'h10);
    wr(2'd3, 7'h03);
    check("R12 route untouched", {irq, txd, rxd}, 3'b100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule